// File: doc/BRIEF.md
# Comparator Output Routing and Change Flag

This block takes the two result bits of a pair of analog comparators, which reach it as plain logic levels, and makes them available in three ways. Software sees them as read-only status bits, after a two-flop synchronizer. Two port pins can carry them to the outside world when the mode field selects routing. A sticky change flag tells software that the comparator state has moved since it last read the status.

Each status read strobe copies the synchronized comparator bits into a holding register. From then on, a difference between the synchronized bits and that copy raises the flag. The flag stays raised until software clears it. A clear request made while the difference still exists has no effect. In routing mode the pins carry the raw comparator levels, which bypass the synchronizer. The per-pin tristate controls still decide whether each pin drives. The port read path returns zero for any pin that is configured as analog.

Top module: `cmp_route_flag`

## Requirements
- R1: `stat_cmp` equals `cmp_raw` delayed by exactly two clock edges (two-flop synchronizer). While `rst_n` is low it is 0.
- R2: When `mode` is 3'b110, `pin_out[i]` equals `cmp_raw[i]` in the same cycle, with no register in the path.
- R3: For every `mode` value other than 3'b110, `pin_out` equals `port_dout`.
- R4: In every mode, `pin_oe[i]` is the inverse of `port_tris[i]`. A value of 1 in `port_tris` means the pin is an input and is not driven.
- R5: A high `rd_stat` at a clock edge loads the current `stat_cmp` into the holding register. Reset clears the holding register to 0.
- R6: `flag` is 0 after reset. It reads 1 one cycle after any edge at which `stat_cmp` differs from the holding register.
- R7: Once set, `flag` stays 1 until `flag_clr` is high at an edge where no difference exists. It reads 0 after that edge.
- R8: A `flag_clr` at an edge where a difference exists is overridden, and `flag` reads 1 after that edge.
- R9: `port_rd[i]` equals `pin_in[i]` when `pin_analog[i]` is 0, and equals 0 when `pin_analog[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmp_raw | input | 2 | Comparator result levels, asynchronous |
| mode | input | 3 | Comparator mode field; 3'b110 routes results to pins |
| rd_stat | input | 1 | Status register read strobe |
| flag_clr | input | 1 | Software clear of the change flag |
| port_dout | input | 2 | Normal port output data for the two pins |
| port_tris | input | 2 | Tristate control, 1 = input (undriven) |
| pin_in | input | 2 | Digital level seen at each pin |
| pin_analog | input | 2 | 1 = pin configured as analog |
| stat_cmp | output | 2 | Synchronized comparator bits (read-only status) |
| flag | output | 1 | Sticky comparator-change flag |
| pin_out | output | 2 | Pin output value |
| pin_oe | output | 2 | Pin output enable |
| port_rd | output | 2 | Port read value |

## Verification
The bench clears the flag while a mismatch is still present. A design that let the clear win would drop the flag and lose the event. The bench also lets a mismatch disappear through a status read without clearing the flag, which catches a flag that only follows the live comparison. It switches the mode between 3'b110 and its neighbours while the comparator inputs change. A design that registered the routed path, or decoded the wrong mode code, would show stale or port data on the pins. The bench also sets tristate and analog bits during routing, which catches a design that drives an input pin or reads back analog levels.

// File: rtl/cmp_route_pkg.sv
package cmp_route_pkg;
  localparam int unsigned N_CMP = 2;
  localparam int unsigned MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_ROUTE = 3'b110;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_change_det.sv
module cmp_change_det #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic             capture,
  input  logic             clr,
  output logic [WIDTH-1:0] held,
  output logic             differ,
  output logic             flag
);
  logic [WIDTH-1:0] held_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (capture) held_q <= cur;
  end

  assign differ = |(cur ^ held_q);

  // a live difference always wins over a clear request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (differ) flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  assign held = held_q;
  assign flag = flag_q;
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
  import cmp_route_pkg::*;
#(
  parameter int unsigned NPIN = 2
) (
  input  mode_t           mode,
  input  logic [NPIN-1:0] raw,
  input  logic [NPIN-1:0] dout,
  input  logic [NPIN-1:0] tris,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] analog,
  output logic [NPIN-1:0] out,
  output logic [NPIN-1:0] oe,
  output logic [NPIN-1:0] rd
);
  logic route_sel;
  assign route_sel = (mode == MODE_ROUTE);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign out[i] = route_sel ? raw[i] : dout[i];
    assign oe[i]  = ~tris[i];
    assign rd[i]  = pad_in[i] & ~analog[i];
  end
endmodule

// File: rtl/cmp_route_flag.sv
module cmp_route_flag
  import cmp_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] cmp_raw,
  input  logic [2:0]       mode,
  input  logic             rd_stat,
  input  logic             flag_clr,
  input  logic [N_CMP-1:0] port_dout,
  input  logic [N_CMP-1:0] port_tris,
  input  logic [N_CMP-1:0] pin_in,
  input  logic [N_CMP-1:0] pin_analog,
  output logic [N_CMP-1:0] stat_cmp,
  output logic             flag,
  output logic [N_CMP-1:0] pin_out,
  output logic [N_CMP-1:0] pin_oe,
  output logic [N_CMP-1:0] port_rd
);
  logic [N_CMP-1:0] sync_cmp;
  logic [N_CMP-1:0] held_cmp;
  logic             cmp_differ;

  cmp_sync #(.WIDTH(N_CMP), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(sync_cmp)
  );

  cmp_change_det #(.WIDTH(N_CMP)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(sync_cmp), .capture(rd_stat),
    .clr(flag_clr), .held(held_cmp), .differ(cmp_differ), .flag(flag)
  );

  cmp_pin_mux #(.NPIN(N_CMP)) u_mux (
    .mode(mode), .raw(cmp_raw), .dout(port_dout), .tris(port_tris),
    .pad_in(pin_in), .analog(pin_analog),
    .out(pin_out), .oe(pin_oe), .rd(port_rd)
  );

  assign stat_cmp = sync_cmp;
endmodule

// File: rtl/cmp_route_flag_chk.sv
module cmp_route_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmp_raw,
  input logic [2:0] mode,
  input logic       rd_stat,
  input logic       flag_clr,
  input logic [1:0] port_dout,
  input logic [1:0] port_tris,
  input logic [1:0] pin_in,
  input logic [1:0] pin_analog,
  input logic [1:0] stat_cmp,
  input logic       flag,
  input logic [1:0] pin_out,
  input logic [1:0] pin_oe,
  input logic [1:0] port_rd,
  input logic [1:0] held_cmp
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (stat_cmp == $past(cmp_raw, 2)));

  p_route_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110) |-> (pin_out == cmp_raw));

  p_port_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b110) |-> (pin_out == port_dout));

  p_oe_tris_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == ~port_tris));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (held_cmp == $past(stat_cmp)));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_cmp != held_cmp) |=> flag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  p_clr_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && (stat_cmp != held_cmp)) |=> flag);

  p_analog_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_rd & pin_analog) == 2'b00));
endmodule

bind cmp_route_flag cmp_route_flag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .mode(mode),
  .rd_stat(rd_stat), .flag_clr(flag_clr), .port_dout(port_dout),
  .port_tris(port_tris), .pin_in(pin_in), .pin_analog(pin_analog),
  .stat_cmp(stat_cmp), .flag(flag), .pin_out(pin_out), .pin_oe(pin_oe),
  .port_rd(port_rd), .held_cmp(held_cmp)
);

// File: tb/sim_cmp_route_flag.sv
`timescale 1ns/1ps
module sim_cmp_route_flag;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmp_raw = '0;
  logic [2:0] mode = '0;
  logic       rd_stat = 1'b0;
  logic       flag_clr = 1'b0;
  logic [1:0] port_dout = '0;
  logic [1:0] port_tris = '0;
  logic [1:0] pin_in = '0;
  logic [1:0] pin_analog = '0;
  logic [1:0] stat_cmp;
  logic       flag;
  logic [1:0] pin_out;
  logic [1:0] pin_oe;
  logic [1:0] port_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] m_s1 = '0, m_s2 = '0, m_hold = '0;
  logic       m_flag = 1'b0;

  always #5 clk = ~clk;

  cmp_route_flag u0 (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .mode(mode),
    .rd_stat(rd_stat), .flag_clr(flag_clr), .port_dout(port_dout),
    .port_tris(port_tris), .pin_in(pin_in), .pin_analog(pin_analog),
    .stat_cmp(stat_cmp), .flag(flag), .pin_out(pin_out), .pin_oe(pin_oe),
    .port_rd(port_rd)
  );

  function automatic logic [1:0] exp_pin(input logic [2:0] md, input logic [1:0] raw,
                                         input logic [1:0] dout);
    return (md == 3'b110) ? raw : dout;
  endfunction

  function automatic logic [1:0] exp_rd(input logic [1:0] pin, input logic [1:0] ana);
    return pin & ~ana;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [3:0] act,
                     input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] raw, input logic rd, input logic clr,
                      input logic [2:0] md, input logic [1:0] dout,
                      input logic [1:0] tris, input logic [1:0] pin,
                      input logic [1:0] ana);
    logic       f_n;
    cmp_raw = raw; rd_stat = rd; flag_clr = clr; mode = md;
    port_dout = dout; port_tris = tris; pin_in = pin; pin_analog = ana;
    #1;
    if (md == 3'b110)
      chk(pin_out == exp_pin(md, raw, dout), "R2 routed pin", {2'b0, pin_out}, {2'b0, exp_pin(md, raw, dout)});
    else
      chk(pin_out == exp_pin(md, raw, dout), "R3 port data pin", {2'b0, pin_out}, {2'b0, exp_pin(md, raw, dout)});
    chk(pin_oe == ~tris, "R4 output enable", {2'b0, pin_oe}, {2'b0, ~tris});
    chk(port_rd == exp_rd(pin, ana), "R9 port read", {2'b0, port_rd}, {2'b0, exp_rd(pin, ana)});
    @(posedge clk);
    f_n = (m_s2 != m_hold) | (m_flag & ~clr);
    if (rd) m_hold = m_s2;
    m_flag = f_n;
    m_s2 = m_s1;
    m_s1 = raw;
    @(negedge clk);
    chk(stat_cmp == m_s2, "R1 status sync", {2'b0, stat_cmp}, {2'b0, m_s2});
    chk(flag == m_flag, "R5 R6 R7 R8 change flag", {3'b0, flag}, {3'b0, m_flag});
  endtask

  initial begin : watchdog
    #(10 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1357);
    cmp_raw = 2'b11;
    repeat (3) @(negedge clk);
    chk(stat_cmp == 2'b00, "R1 reset status", {2'b0, stat_cmp}, 4'h0);
    chk(flag == 1'b0, "R6 reset flag", {3'b0, flag}, 4'h0);
    cmp_raw = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;

    // directed: flag rises from a change versus the reset capture (R6)
    step(2'b01, 0, 0, 3'b000, 2'b10, 2'b00, 2'b11, 2'b00);
    step(2'b01, 0, 0, 3'b000, 2'b10, 2'b00, 2'b11, 2'b00);
    step(2'b01, 0, 0, 3'b000, 2'b10, 2'b00, 2'b11, 2'b00);
    chk(flag == 1'b1, "R6 flag raised", {3'b0, flag}, 4'h1);
    // read removes the mismatch; flag must stay (R5, R7)
    step(2'b01, 1, 0, 3'b110, 2'b10, 2'b00, 2'b11, 2'b01);
    step(2'b01, 0, 0, 3'b110, 2'b10, 2'b10, 2'b11, 2'b10);
    chk(flag == 1'b1, "R7 flag sticky", {3'b0, flag}, 4'h1);
    step(2'b01, 0, 1, 3'b111, 2'b01, 2'b01, 2'b10, 2'b00);
    chk(flag == 1'b0, "R7 flag cleared", {3'b0, flag}, 4'h0);
    // clear during a live mismatch is overridden (R8)
    step(2'b10, 0, 0, 3'b110, 2'b00, 2'b11, 2'b01, 2'b11);
    step(2'b10, 0, 0, 3'b110, 2'b00, 2'b11, 2'b01, 2'b11);
    step(2'b10, 0, 1, 3'b010, 2'b11, 2'b00, 2'b00, 2'b00);
    step(2'b10, 0, 1, 3'b100, 2'b11, 2'b00, 2'b00, 2'b00);
    chk(flag == 1'b1, "R8 clear overridden", {3'b0, flag}, 4'h1);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] md;
      md = ($urandom % 3 == 0) ? 3'b110 : 3'($urandom);
      step(2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, md,
           2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule